// File: doc/BRIEF.md
# HDLC Controller Status Register

This block assembles the 8-bit status word that software reads from an HDLC controller. It keeps a sticky interrupt flag, watches the receive serial bit stream for an idle channel (a run of fifteen or more ones), passes through the tag of the byte at the head of the receive FIFO, and encodes the fill level of the transmit and receive FIFOs into two-bit codes.

The FIFOs, the framer and the interrupt mask live elsewhere. This block receives occupancy counts, thresholds and depths as plain inputs. The read data is purely combinational from the current state and inputs. A read strobe clears the interrupt flag on the following clock edge.

Bit layout: bit 7 is the interrupt flag, bit 6 is the idle indication, bits 5:4 are the head tag, bits 3:2 are the transmit FIFO code, and bits 1:0 are the receive FIFO code.

Top module: `hdlc_stat_reg`

## Requirements
- R1: After reset bit 7 reads 0. A cycle with `irq_evt` high makes bit 7 read 1 from the next clock edge. A cycle with `rd_stb` high and `irq_evt` low makes bit 7 read 0 from the next edge. Otherwise bit 7 holds its value.
- R2: When `irq_evt` and `rd_stb` are high in the same cycle, bit 7 reads 1 after that edge.
- R3: After fifteen consecutive strobed ones (`rx_bit_vld` high, `rx_bit` 1), bit 6 reads 1 and stays 1 while further ones arrive. A strobed zero makes bit 6 read 0 from the next edge.
- R4: While `rx_bit_vld` is low, `rx_bit` has no effect, and bit 6 keeps its value across the edge.
- R5: From reset, bit 6 reads 1 until the detector becomes valid. It becomes valid on the first strobed zero, or once fifteen strobed ones have been seen.
- R6: Bits 5:4 equal `rx_tag`, where 00 is a packet byte, 01 a first byte, 10 the last byte of a good packet and 11 the last byte of a bad packet.
- R7: Bits 3:2 encode the transmit FIFO, with the first matching rule applied: count 0 gives 10; count >= depth gives 00; count >= threshold gives 01; otherwise 11.
- R8: Bits 1:0 encode the receive FIFO, with the first matching rule applied: count 0 gives 00; count >= depth gives 10; count >= threshold gives 11; otherwise 01.
- R9: Bits 5:0 follow their inputs in the same cycle, with no register between input and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_vld | input | 1 | Strobe marking `rx_bit` as a new bit |
| irq_evt | input | 1 | Masked interrupt event from the controller |
| rd_stb | input | 1 | Status register read strobe |
| rx_tag | input | 2 | Tag of the byte at the receive FIFO head |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_thresh | input | CNT_W | Transmit FIFO threshold |
| tx_depth | input | CNT_W | Transmit FIFO capacity |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_thresh | input | CNT_W | Receive FIFO threshold |
| rx_depth | input | CNT_W | Receive FIFO capacity |
| stat_q | output | 8 | Status read data |

## Verification
The assertions take the occupancy counts as given. They assume that depth is nonzero and that the threshold lies between 1 and depth, so that the threshold codes can be reached. The bench keeps depths fixed at 32 and draws thresholds only from that range. The counts are drawn slightly past depth so that the full code is covered. The bit stream is weighted heavily toward ones so that idle runs of fifteen occur, and the strobe is dropped at random so that the hold behaviour of bit 6 is exercised.

// File: rtl/hdlc_stat_reg.sv
module hdlc_stat_reg #(
  parameter int CNT_W    = 6,
  parameter int IDLE_RUN = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_bit_vld,
  input  logic             irq_evt,
  input  logic             rd_stb,
  input  logic [1:0]       rx_tag,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] tx_thresh,
  input  logic [CNT_W-1:0] tx_depth,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_thresh,
  input  logic [CNT_W-1:0] rx_depth,
  output logic [7:0]       stat_q
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_RUN);
  localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(IDLE_RUN - 1);

  logic             irq_q;
  logic             valid_q;
  logic [RUN_W-1:0] ones_q;
  logic             run_full;
  logic             idle;
  logic [1:0]       tx_code;
  logic [1:0]       rx_code;

  assign run_full = (ones_q == RUN_MAX);
  assign idle     = ~valid_q | run_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      valid_q <= 1'b0;
      ones_q  <= '0;
    end else begin
      irq_q <= irq_evt | (irq_q & ~rd_stb);
      if (rx_bit_vld) begin
        if (!rx_bit) begin
          ones_q  <= '0;
          valid_q <= 1'b1;
        end else begin
          if (!run_full) ones_q <= ones_q + 1'b1;
          if (ones_q >= RUN_PRE) valid_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (tx_count == '0)            tx_code = 2'b10;
    else if (tx_count >= tx_depth) tx_code = 2'b00;
    else if (tx_count >= tx_thresh) tx_code = 2'b01;
    else                           tx_code = 2'b11;
  end

  always_comb begin
    if (rx_count == '0)            rx_code = 2'b00;
    else if (rx_count >= rx_depth) rx_code = 2'b10;
    else if (rx_count >= rx_thresh) rx_code = 2'b11;
    else                           rx_code = 2'b01;
  end

  assign stat_q = {irq_q, idle, rx_tag, tx_code, rx_code};
endmodule

module hdlc_stat_reg_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_bit,
  input logic             rx_bit_vld,
  input logic             irq_evt,
  input logic             rd_stb,
  input logic [1:0]       rx_tag,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic [7:0]       stat_q
);
  p_irq_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> stat_q[7]);
  p_irq_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !irq_evt) |=> !stat_q[7]);
  p_irq_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !irq_evt) |=> $stable(stat_q[7]));
  p_irq_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && irq_evt) |=> stat_q[7]);
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit_vld && !rx_bit) |=> !stat_q[6]);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bit_vld |=> $stable(stat_q[6]));
  p_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[5:4] == rx_tag);
  p_tx_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0) |-> (stat_q[3:2] == 2'b10));
  p_rx_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> (stat_q[1:0] == 2'b00));
endmodule

bind hdlc_stat_reg hdlc_stat_reg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
  .irq_evt(irq_evt), .rd_stb(rd_stb), .rx_tag(rx_tag),
  .tx_count(tx_count), .rx_count(rx_count), .stat_q(stat_q)
);

// File: tb/hdlc_stat_reg_bench.sv
module hdlc_stat_reg_bench;
  localparam int W = 6;
  localparam logic [W-1:0] DEPTH = 6'd32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_bit_vld = 1'b0, irq_evt = 1'b0, rd_stb = 1'b0;
  logic [1:0] rx_tag = 2'b00;
  logic [W-1:0] tx_count = '0, tx_thresh = 6'd8, rx_count = '0, rx_thresh = 6'd8;
  logic [7:0] stat_q;

  int checks = 0;
  int errors = 0;
  int seed_dummy;

  bit m_irq;
  bit m_valid;
  int m_ones;

  always #10 clk = ~clk;

  hdlc_stat_reg #(.CNT_W(W), .IDLE_RUN(15)) u_hdlc_stat_reg (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
    .irq_evt(irq_evt), .rd_stb(rd_stb), .rx_tag(rx_tag),
    .tx_count(tx_count), .tx_thresh(tx_thresh), .tx_depth(DEPTH),
    .rx_count(rx_count), .rx_thresh(rx_thresh), .rx_depth(DEPTH),
    .stat_q(stat_q)
  );

  function automatic logic [1:0] tx_exp(input int c, input int t, input int d);
    if (c == 0) return 2'b10;
    if (c >= d) return 2'b00;
    if (c >= t) return 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [1:0] rx_exp(input int c, input int t, input int d);
    if (c == 0) return 2'b00;
    if (c >= d) return 2'b10;
    if (c >= t) return 2'b11;
    return 2'b01;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: stat_q actual %b expected %b", req, act, exp);
    end
  endtask

  // inputs are already driven at negedge; check combinational view, then clock
  task automatic step(input string req);
    logic [7:0] e;
    #1;
    e = {m_irq, (!m_valid || m_ones == 15), rx_tag,
         tx_exp(int'(tx_count), int'(tx_thresh), int'(DEPTH)),
         rx_exp(int'(rx_count), int'(rx_thresh), int'(DEPTH))};
    chk(req, stat_q, e);
    @(posedge clk);
    m_irq = irq_evt || (m_irq && !rd_stb);
    if (rx_bit_vld) begin
      if (!rx_bit) begin m_ones = 0; m_valid = 1; end
      else begin
        if (m_ones >= 14) m_valid = 1;
        if (m_ones < 15) m_ones++;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    irq_evt = 0; rd_stb = 0; rx_bit_vld = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(1234);
    m_irq = 0; m_valid = 0; m_ones = 0;
    repeat (2) @(negedge clk);
    // R1 R5 reset state: irq 0, idle reads 1 before validity
    chk("R1 R5 reset", stat_q, {1'b0, 1'b1, 2'b00, 2'b10, 2'b00});
    rst_n = 1;
    @(negedge clk);

    // R1 set then clear
    irq_evt = 1; step("R1 set");
    irq_evt = 0; step("R1 hold");
    rd_stb = 1; step("R1 read");
    rd_stb = 0; step("R1 cleared");
    // R2 collision
    irq_evt = 1; rd_stb = 1; step("R2 collide");
    idle_in(); step("R2 kept");
    rd_stb = 1; step("R2 read"); idle_in();

    // R5 fourteen ones: still invalid so bit 6 reads 1; R3 at fifteen
    for (int i = 0; i < 16; i++) begin rx_bit_vld = 1; rx_bit = 1; step("R3 R5 run"); end
    // R4 zero without strobe ignored
    rx_bit_vld = 0; rx_bit = 0; step("R4 ignored");
    step("R4 still idle");
    rx_bit_vld = 1; rx_bit = 0; step("R3 zero");
    rx_bit_vld = 0; step("R3 cleared");

    // R7 R8 boundaries
    foreach (rx_tag[i]) ;
    for (int c = 0; c < 36; c++) begin
      tx_count = W'(c); rx_count = W'(35 - c); tx_thresh = 6'd10; rx_thresh = 6'd20;
      rx_tag = 2'(c); step("R6 R7 R8 sweep");
    end
    tx_thresh = 6'd32; tx_count = 6'd31; step("R7 below max threshold");
    rx_thresh = 6'd1; rx_count = 6'd1; step("R8 threshold one");

    // random mix, R9 combinational view checked every cycle
    for (int n = 0; n < 3000; n++) begin
      irq_evt = ($urandom_range(0, 9) == 0);
      rd_stb = ($urandom_range(0, 5) == 0);
      rx_bit_vld = ($urandom_range(0, 3) != 0);
      rx_bit = ($urandom_range(0, 19) != 0);
      rx_tag = 2'($urandom_range(0, 3));
      tx_thresh = W'($urandom_range(1, 32));
      rx_thresh = W'($urandom_range(1, 32));
      tx_count = W'($urandom_range(0, 34));
      rx_count = W'($urandom_range(0, 34));
      step("R1 R3 R4 R6 R7 R8 R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule